// File: doc/BRIEF.md
# Delayed-Redirect Program Counter

This block owns the fetch address of a small 32-bit load-store core. Each cycle it looks at the decoded control-transfer strobes for the instruction currently at `pc_o`. From these and the operand values it decides whether control leaves the sequential path. The redirect is deferred by one instruction. The instruction just after a taken transfer (the delay slot) is always fetched and executed, and only the fetch after that goes to the target.

A resolved target waits in a pending register with a valid flag through the delay-slot cycle. The link output gives the address just past the delay slot, so a call returns to the first instruction after that slot. A stall freezes all state.

Two misuse cases raise sticky flags that stay set until reset. One is a transfer placed in a delay slot, which is dropped. The other is a register-indirect target that is not word-aligned.

Top module: `fetch_pc_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after its release, `pc_o` holds 0x00400000 and both error flags are 0.
- R2: With no strobe active, no redirect pending and stall low, `pc_o` grows by 4 on each clock.
- R3: A branch is taken when `beq_i` is set and `rs_val_i == rt_val_i`, or when `bne_i` is set and the values differ. Its target is (branch address + 4) + (sign-extended `imm16_i` shifted left by 2). A branch that is not taken causes no redirect.
- R4: The target of `jmp_i` or `jal_i` is bits 31:28 of (PC + 4), then `imm26_i`, then two zero bits.
- R5: The target of `jr_i` is `jr_addr_i` in full, and the current PC plays no part in it.
- R6: After a taken transfer accepted at address A, the next `pc_o` is A + 4 (the delay slot) and the one after that is the target.
- R7: `link_addr_o` always carries `pc_o` + 8. `link_we_o` is 1 exactly in the cycle in which a jump-and-link is accepted.
- R8: While `stall_i` is high, `pc_o`, the pending redirect and both error flags hold their values, and `link_we_o` is 0.
- R9: Any strobe seen while the delay slot is at `pc_o` is ignored, so the pending redirect goes ahead unchanged, and `slot_err_o` sets and stays set.
- R10: An accepted jump-register whose target has bits 1:0 not equal to 00 sets `align_err_o`, which stays set. The target is still used unchanged.
- R11: When several strobes are active together, jump-register wins over jump-and-link, jump-and-link wins over jump, and jump wins over the branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze all state for this cycle |
| beq_i | input | 1 | Branch-if-equal decoded |
| bne_i | input | 1 | Branch-if-not-equal decoded |
| jmp_i | input | 1 | Absolute jump decoded |
| jal_i | input | 1 | Jump-and-link decoded |
| jr_i | input | 1 | Jump-register decoded |
| rs_val_i | input | 32 | First compared value |
| rt_val_i | input | 32 | Second compared value |
| imm16_i | input | 16 | Branch word offset |
| imm26_i | input | 26 | Jump word index |
| jr_addr_i | input | 32 | Register target for jump-register |
| pc_o | output | 32 | Current fetch address |
| link_addr_o | output | 32 | Return address (PC + 8) |
| link_we_o | output | 1 | Write link to register 31 |
| slot_err_o | output | 1 | Sticky: transfer seen in a delay slot |
| align_err_o | output | 1 | Sticky: misaligned jump-register target |

## Verification
Two functions can fall in the same cycle. The first is applying a pending redirect while a fresh transfer strobe arrives in the delay slot. The second is a stall landing on either the decode cycle or the delay-slot cycle of a transfer. The bench provokes both by placing a jump or a jump-and-link in the slot and by holding stall across each of the two cycles. Every cycle it compares PC, link and flags against a behavioural model of deferred redirection. The judgement is that the original target still arrives exactly one instruction late, that no link write leaks out during a stall, and that the slot flag rises.

// File: rtl/fetch_pc_pkg.sv
package fetch_pc_pkg;
  localparam logic [31:0] RESET_PC_DEF = 32'h0040_0000;

  typedef enum logic [2:0] {
    XFER_NONE,
    XFER_BR,
    XFER_J,
    XFER_JAL,
    XFER_JR
  } xfer_e;
endpackage

// File: rtl/npc_branch_cmp.sv
module npc_branch_cmp #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         beq_i,
  input  logic         bne_i,
  output logic         take_o
);
  logic eq;
  assign eq     = (a_i == b_i);
  assign take_o = (beq_i & eq) | (bne_i & ~eq);
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import fetch_pc_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic              br_take_i,
  input  logic              jmp_i,
  input  logic              jal_i,
  input  logic              jr_i,
  input  logic [IMM_W-1:0]  imm16_i,
  input  logic [JIDX_W-1:0] imm26_i,
  input  logic [XLEN-1:0]   jr_addr_i,
  output xfer_e             kind_o,
  output logic [XLEN-1:0]   target_o
);
  localparam int unsigned SEXT_W = XLEN - IMM_W - 2;
  localparam int unsigned HI_W   = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] pc_plus4, br_off, br_tgt, j_tgt;

  assign pc_plus4 = pc_i + XLEN'(4);
  assign br_off   = {{SEXT_W{imm16_i[IMM_W-1]}}, imm16_i, 2'b00};
  assign br_tgt   = pc_plus4 + br_off;
  assign j_tgt    = {pc_plus4[XLEN-1 -: HI_W], imm26_i, 2'b00};

  // fixed priority: register > link > jump > branch
  always_comb begin
    kind_o   = XFER_NONE;
    target_o = br_tgt;
    if (jr_i) begin
      kind_o   = XFER_JR;
      target_o = jr_addr_i;
    end else if (jal_i) begin
      kind_o   = XFER_JAL;
      target_o = j_tgt;
    end else if (jmp_i) begin
      kind_o   = XFER_J;
      target_o = j_tgt;
    end else if (br_take_i) begin
      kind_o   = XFER_BR;
    end
  end
endmodule

// File: rtl/npc_pc_state.sv
module npc_pc_state #(
  parameter int unsigned     XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            strobe_any_i,
  input  logic            taken_i,
  input  logic            misalign_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] pc_o,
  output logic            pend_vld_o,
  output logic [XLEN-1:0] pend_tgt_o,
  output logic            accept_o,
  output logic            slot_err_o,
  output logic            align_err_o
);
  logic [XLEN-1:0] pc_q, pend_tgt_q;
  logic            pend_vld_q, slot_err_q, align_err_q;

  assign accept_o = taken_i & ~stall_i & ~pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= RESET_PC;
      pend_tgt_q  <= '0;
      pend_vld_q  <= 1'b0;
      slot_err_q  <= 1'b0;
      align_err_q <= 1'b0;
    end else if (!stall_i) begin
      if (pend_vld_q) begin
        // delay slot executing: apply the held redirect, drop any new strobe
        pc_q       <= pend_tgt_q;
        pend_vld_q <= 1'b0;
        if (strobe_any_i) slot_err_q <= 1'b1;
      end else begin
        pc_q <= pc_q + XLEN'(4);
        if (taken_i) begin
          pend_vld_q <= 1'b1;
          pend_tgt_q <= target_i;
          if (misalign_i) align_err_q <= 1'b1;
        end
      end
    end
  end

  assign pc_o        = pc_q;
  assign pend_vld_o  = pend_vld_q;
  assign pend_tgt_o  = pend_tgt_q;
  assign slot_err_o  = slot_err_q;
  assign align_err_o = align_err_q;
endmodule

// File: rtl/fetch_pc_ctrl.sv
module fetch_pc_ctrl
  import fetch_pc_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     IMM_W    = 16,
  parameter int unsigned     JIDX_W   = 26,
  parameter logic [XLEN-1:0] RESET_PC = RESET_PC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              beq_i,
  input  logic              bne_i,
  input  logic              jmp_i,
  input  logic              jal_i,
  input  logic              jr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  input  logic [IMM_W-1:0]  imm16_i,
  input  logic [JIDX_W-1:0] imm26_i,
  input  logic [XLEN-1:0]   jr_addr_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   link_addr_o,
  output logic              link_we_o,
  output logic              slot_err_o,
  output logic              align_err_o
);
  logic            br_take, taken, accept, misalign, strobe_any;
  logic            pend_vld_q;
  logic [XLEN-1:0] pend_tgt_q, target;
  xfer_e           kind;

  npc_branch_cmp #(.W(XLEN)) u_cmp (
    .a_i   (rs_val_i),
    .b_i   (rt_val_i),
    .beq_i (beq_i),
    .bne_i (bne_i),
    .take_o(br_take)
  );

  npc_target_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_i     (pc_o),
    .br_take_i(br_take),
    .jmp_i    (jmp_i),
    .jal_i    (jal_i),
    .jr_i     (jr_i),
    .imm16_i  (imm16_i),
    .imm26_i  (imm26_i),
    .jr_addr_i(jr_addr_i),
    .kind_o   (kind),
    .target_o (target)
  );

  assign taken      = (kind != XFER_NONE);
  assign misalign   = (kind == XFER_JR) && (jr_addr_i[1:0] != 2'b00);
  assign strobe_any = beq_i | bne_i | jmp_i | jal_i | jr_i;

  npc_pc_state #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .strobe_any_i(strobe_any),
    .taken_i     (taken),
    .misalign_i  (misalign),
    .target_i    (target),
    .pc_o        (pc_o),
    .pend_vld_o  (pend_vld_q),
    .pend_tgt_o  (pend_tgt_q),
    .accept_o    (accept),
    .slot_err_o  (slot_err_o),
    .align_err_o (align_err_o)
  );

  // return point skips the delay slot
  assign link_addr_o = pc_o + XLEN'(8);
  assign link_we_o   = accept && (kind == XFER_JAL);
endmodule

// File: rtl/fetch_pc_ctrl_chk.sv
module fetch_pc_ctrl_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic            beq_i,
  input logic            bne_i,
  input logic            jmp_i,
  input logic            jal_i,
  input logic            jr_i,
  input logic [XLEN-1:0] pc_o,
  input logic            link_we_o,
  input logic            slot_err_o,
  input logic            align_err_o,
  input logic            pend_vld_q,
  input logic [XLEN-1:0] pend_tgt_q
);
  logic any_strobe;
  assign any_strobe = beq_i | bne_i | jmp_i | jal_i | jr_i;

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !pend_vld_q && !any_strobe) |=> (pc_o == $past(pc_o) + XLEN'(4)));

  p_redirect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld_q && !stall_i) |=> (pc_o == $past(pend_tgt_q) && !pend_vld_q));

  p_jal_defers_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |=> (pend_vld_q && pc_o == $past(pc_o) + XLEN'(4)));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(pc_o) && $stable(pend_vld_q) && $stable(pend_tgt_q)));

  p_no_link_on_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !link_we_o);

  p_slot_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_err_o |=> slot_err_o);

  p_align_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |=> align_err_o);
endmodule

bind fetch_pc_ctrl fetch_pc_ctrl_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stall_i    (stall_i),
  .beq_i      (beq_i),
  .bne_i      (bne_i),
  .jmp_i      (jmp_i),
  .jal_i      (jal_i),
  .jr_i       (jr_i),
  .pc_o       (pc_o),
  .link_we_o  (link_we_o),
  .slot_err_o (slot_err_o),
  .align_err_o(align_err_o),
  .pend_vld_q (pend_vld_q),
  .pend_tgt_q (pend_tgt_q)
);

// File: tb/fetch_pc_ctrl_tb_top.sv
module fetch_pc_ctrl_tb_top;
  logic        clk_i = 0, rst_ni = 0, stall_i = 0;
  logic        beq_i = 0, bne_i = 0, jmp_i = 0, jal_i = 0, jr_i = 0;
  logic [31:0] rs_val_i = 0, rt_val_i = 0, jr_addr_i = 0;
  logic [15:0] imm16_i = 0;
  logic [25:0] imm26_i = 0;
  logic [31:0] pc_o, link_addr_o;
  logic        link_we_o, slot_err_o, align_err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_pc = 32'h0040_0000, m_tgt = 0;
  bit m_pend = 0, m_serr = 0, m_aerr = 0;

  always #5 clk_i = ~clk_i;

  fetch_pc_ctrl dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one instruction cycle: drive at negedge, compare, advance model at posedge
  task automatic step(string req, logic st, logic b_eq, logic b_ne, logic j, logic jl,
                      logic r, logic [31:0] a, logic [31:0] b, logic [15:0] i16,
                      logic [25:0] i26, logic [31:0] ra);
    logic [31:0] p4, tgt;
    bit any, tk, exp_we;
    stall_i = st; beq_i = b_eq; bne_i = b_ne; jmp_i = j; jal_i = jl; jr_i = r;
    rs_val_i = a; rt_val_i = b; imm16_i = i16; imm26_i = i26; jr_addr_i = ra;
    #1;
    exp_we = !st && !m_pend && jl && !r;
    chk({req, " pc"}, pc_o, m_pc);
    chk({req, " R7 link_we"}, {31'b0, link_we_o}, {31'b0, exp_we});
    chk({req, " R7 link_addr"}, link_addr_o, m_pc + 32'd8);
    chk({req, " R9 slot_err"}, {31'b0, slot_err_o}, {31'b0, m_serr});
    chk({req, " R10 align_err"}, {31'b0, align_err_o}, {31'b0, m_aerr});
    @(posedge clk_i);
    any = b_eq | b_ne | j | jl | r;
    p4  = m_pc + 32'd4;
    if (!st) begin
      if (m_pend) begin
        if (any) m_serr = 1;
        m_pc   = m_tgt;
        m_pend = 0;
      end else begin
        tk = 1;
        if (r) tgt = ra;
        else if (j || jl) tgt = {p4[31:28], i26, 2'b00};
        else if ((b_eq && a == b) || (b_ne && a != b))
          tgt = p4 + {{14{i16[15]}}, i16, 2'b00};
        else begin tk = 0; tgt = 0; end
        if (tk) begin
          m_pend = 1; m_tgt = tgt;
          if (r && ra[1:0] != 2'b00) m_aerr = 1;
        end
        m_pc = p4;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R1 reset pc", pc_o, 32'h0040_0000);
    chk("R1 reset flags", {30'b0, slot_err_o, align_err_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1;
    chk("R1 after release", pc_o, 32'h0040_0000);
    repeat (3) idle("R2 sequential");
    // R3 beq taken, forward offset; R6 slot then target
    step("R3 beq taken", 0, 1, 0, 0, 0, 0, 32'h55, 32'h55, 16'h0003, 0, 0);
    idle("R6 delay slot");
    idle("R6 at target");
    step("R3 beq not taken", 0, 1, 0, 0, 0, 0, 32'h1, 32'h2, 16'h0010, 0, 0);
    idle("R3 no redirect");
    step("R3 bne taken backward", 0, 0, 1, 0, 0, 0, 32'h1, 32'h2, 16'hFFFE, 0, 0);
    idle("R6 delay slot");
    idle("R6 at target");
    step("R3 bne not taken", 0, 0, 1, 0, 0, 0, 32'h7, 32'h7, 16'h0040, 0, 0);
    idle("R3 no redirect");
    step("R4 jump", 0, 0, 0, 1, 0, 0, 0, 0, 0, 26'h0100040, 0);
    idle("R6 delay slot");
    idle("R4 at target");
    step("R7 jal", 0, 0, 0, 0, 1, 0, 0, 0, 0, 26'h0100200, 0);
    idle("R7 delay slot");
    idle("R7 at target");
    step("R5 jr", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0040_0100);
    idle("R5 delay slot");
    idle("R5 at target");
    // R8 stall on decode cycle of jal, then stall in delay slot
    step("R8 stall jal", 1, 0, 0, 0, 1, 0, 0, 0, 0, 26'h0100300, 0);
    step("R8 stall jal again", 1, 0, 0, 0, 1, 0, 0, 0, 0, 26'h0100300, 0);
    step("R8 jal released", 0, 0, 0, 0, 1, 0, 0, 0, 0, 26'h0100300, 0);
    step("R8 stall in slot", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R8 slot resumes");
    idle("R8 at target");
    // R9 transfer inside delay slot ignored
    step("R9 jump", 0, 0, 0, 1, 0, 0, 0, 0, 0, 26'h0100080, 0);
    step("R9 jal in slot", 0, 0, 0, 0, 1, 0, 0, 0, 0, 26'h0000010, 0);
    idle("R9 original target");
    idle("R9 flag sticky");
    // R10 misaligned register target
    step("R10 jr misaligned", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0040_0102);
    idle("R10 delay slot");
    idle("R10 at target");
    idle("R10 flag sticky");
    // R11 priority: jr over jal, jal over jump, jump over branch
    step("R11 jr+jal", 0, 0, 0, 0, 1, 1, 0, 0, 0, 26'h0000020, 32'h0040_0800);
    idle("R11 slot");
    idle("R11 jr target");
    step("R11 jal+j", 0, 0, 0, 1, 1, 0, 0, 0, 0, 26'h0100400, 0);
    idle("R11 slot");
    idle("R11 jal target");
    step("R11 j+beq", 0, 1, 0, 1, 0, 0, 32'h3, 32'h3, 16'h0002, 26'h0100500, 0);
    idle("R11 slot");
    idle("R11 j target");
    repeat (2) idle("R2 sequential tail");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule